// File: doc/BRIEF.md
# Filtered Serial Configuration Register Bank

This block is a serial slave that receives 8-bit command words and stores the payload of each one in one of five configuration registers. The registers hold the filter frequency code, the gain code, the integrator time-constant code, the prescaler code and a test/channel control word. The chip-select, serial-clock, serial-data and comparator pins are brought into the system clock domain through two-flop synchronisers. All edge detection and framing then run at the system clock rate. The system clock is expected to run at least eight times faster than the serial clock.

A framing filter accepts a word only when the serial clock is low as chip select falls, and exactly eight complete low-high-low clock pulses follow. The clock must also be low again when chip select rises. Only that rising chip-select edge commits the buffered word. Any other pattern is thrown away, and no register changes. The filter is a four-state machine. FR_IDLE waits for chip select to fall. On that event it goes to FR_WAIT_RISE if the clock is low, or to FR_REJECT if the clock is high. FR_WAIT_RISE moves to FR_CLK_HIGH on a clock rise and shifts one bit in. If eight bits are already held, that rise sends it to FR_REJECT instead. FR_CLK_HIGH returns to FR_WAIT_RISE on a clock fall. Every state returns to FR_IDLE when chip select rises. A commit happens only on the way from FR_WAIT_RISE with a full count. FR_REJECT stays put until chip select rises.

A diagnostic multiplexer drives the serial output. Three sources are available: a readback of the last written register, the synchronised serial input, or the synchronised comparator input.

Top module: `cfg_spi_bank`

## Requirements
- R1: A word is sampled from spi_si on each rising spi_sck while spi_cs_n is low, first bit sent as bit 7. Bits 7:5 are the address: 0 is the frequency, 1 the gain, 2 the integrator, 3 the prescaler and 4 the test/channel register. Bits 4:0 are the payload written to the addressed register.
- R2: If spi_sck is high when spi_cs_n falls, the whole frame is discarded.
- R3: A frame with any number of clock pulses other than eight is discarded.
- R4: If spi_sck is high when spi_cs_n rises, the frame is discarded.
- R5: A valid word changes its register only after spi_cs_n rises. Until then, every register keeps its old value.
- R6: Words with address 5, 6 or 7 change no register and do not change the readback address.
- R7: An active-low reset clears all five registers and drives spi_so low.
- R8: In the test/channel register, bit 4 enables diagnostic output and bits 3:2 pick the source. With bit 4 clear, or with source code 3, spi_so is low.
- R9: With source code 0, spi_so shifts out the last valid address and then that register's payload, 8 bits, first bit sent being address bit 2. The frame is loaded when spi_cs_n falls, and the next bit appears after each falling spi_sck.
- R10: With source code 1, spi_so follows spi_si after the synchroniser delay.
- R11: With source code 2, spi_so follows comp_in after the synchroniser delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| comp_in | input | 1 | External comparator bit for diagnostics |
| spi_so | output | 1 | Diagnostic serial output |
| freq_cfg | output | 5 | Filter frequency code |
| gain_cfg | output | 5 | Gain code |
| integ_cfg | output | 5 | Integrator time-constant code |
| presc_cfg | output | 5 | Prescaler code |
| test_cfg | output | 5 | Test/channel control word |

## Verification
Some properties are checked on every cycle. The bit counter never goes past eight. A commit always comes with a return to idle and a full count. The reject state holds until chip select rises. The register bank stays still when no commit is present or the address is out of range. The output stays low while diagnostics are off. Other behaviour needs the bench's framed scenarios to show it. These include the start and end clock-level rules, seven and nine pulse frames, the bit order and readback address of the shifted frame, and the following of the data and comparator pins. The bench drives these as directed cases and as seeded random frames, and checks them against a model of the register bank.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

    localparam int WORD_W_DEF   = 8;
    localparam int ADDR_W_DEF   = 3;
    localparam int SYNC_DEPTH   = 2;

    typedef enum logic [1:0] {
        FR_IDLE      = 2'd0,
        FR_WAIT_RISE = 2'd1,
        FR_CLK_HIGH  = 2'd2,
        FR_REJECT    = 2'd3
    } frame_state_e;

    typedef enum logic [1:0] {
        SO_SRC_REG  = 2'd0,
        SO_SRC_SI   = 2'd1,
        SO_SRC_COMP = 2'd2,
        SO_SRC_NONE = 2'd3
    } so_src_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], pin_i[g]};
            end
        end

        assign lvl_o[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import cfg_spi_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise_i,
    input  logic              cs_fall_i,
    input  logic              sck_lvl_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              si_lvl_i,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    frame_state_e      state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [WORD_W-1:0] shift_q;
    logic              commit_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE: begin
                if (cs_fall_i) begin
                    state_d = sck_lvl_i ? FR_REJECT : FR_WAIT_RISE;
                end
            end
            FR_WAIT_RISE: begin
                if (cs_rise_i) begin
                    state_d = FR_IDLE;
                end else if (sck_rise_i) begin
                    state_d = (bit_cnt_q == FULL_CNT) ? FR_REJECT : FR_CLK_HIGH;
                end
            end
            FR_CLK_HIGH: begin
                if (cs_rise_i) begin
                    state_d = FR_IDLE;
                end else if (sck_fall_i) begin
                    state_d = FR_WAIT_RISE;
                end
            end
            FR_REJECT: begin
                if (cs_rise_i) begin
                    state_d = FR_IDLE;
                end
            end
            default: state_d = FR_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            commit_q  <= 1'b0;
        end else begin
            commit_q <= (state_q == FR_WAIT_RISE) && cs_rise_i && (bit_cnt_q == FULL_CNT);
            if (state_q == FR_IDLE && cs_fall_i) begin
                bit_cnt_q <= '0;
            end else if (state_q == FR_WAIT_RISE && sck_rise_i && !cs_rise_i
                         && bit_cnt_q != FULL_CNT) begin
                shift_q   <= {shift_q[WORD_W-2:0], si_lvl_i};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    assign commit_o = commit_q;
    assign word_o   = shift_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= FULL_CNT); // R3

    AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> bit_cnt_q == FULL_CNT); // R3

    AST_COMMIT_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> state_q == FR_IDLE); // R5

    AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_REJECT && !cs_rise_i) |=> state_q == FR_REJECT); // R2

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 5,
    parameter int NUM_REGS = 5,
    localparam int WORD_W  = ADDR_W + DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_i,
    input  logic [WORD_W-1:0]          word_i,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat_o,
    output logic [ADDR_W-1:0]          last_addr_o
);

    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] payload;
    logic              addr_ok;
    logic [ADDR_W-1:0] last_addr_q;

    assign addr    = word_i[WORD_W-1 -: ADDR_W];
    assign payload = word_i[DATA_W-1:0];
    assign addr_ok = ({1'b0, addr} < (ADDR_W+1)'(NUM_REGS));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [DATA_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (commit_i && addr == ADDR_W'(r)) begin
                val_q <= payload;
            end
        end

        assign regs_flat_o[r*DATA_W +: DATA_W] = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr_q <= '0;
        end else if (commit_i && addr_ok) begin
            last_addr_q <= addr;
        end
    end

    assign last_addr_o = last_addr_q;

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(regs_flat_o)); // R5

    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !addr_ok) |=> ($stable(regs_flat_o) && $stable(last_addr_o))); // R6

endmodule

// File: rtl/diag_so_mux.sv
module diag_so_mux
    import cfg_spi_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 5,
    parameter int NUM_REGS = 5,
    localparam int RB_W    = ADDR_W + DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_lvl_i,
    input  logic                       cs_fall_i,
    input  logic                       sck_fall_i,
    input  logic                       si_lvl_i,
    input  logic                       comp_lvl_i,
    input  logic [NUM_REGS*DATA_W-1:0] regs_flat_i,
    input  logic [ADDR_W-1:0]          last_addr_i,
    input  logic                       diag_en_i,
    input  logic [1:0]                 src_i,
    output logic                       so_o
);

    logic [DATA_W-1:0] sel_val;
    logic [RB_W-1:0]   rb_shift_q;
    logic              so_d, so_q;
    so_src_e           src;

    assign src = so_src_e'(src_i);

    always_comb begin
        sel_val = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (last_addr_i == ADDR_W'(r)) begin
                sel_val = regs_flat_i[r*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_shift_q <= '0;
        end else if (cs_fall_i) begin
            rb_shift_q <= {last_addr_i, sel_val};
        end else if (sck_fall_i && !cs_lvl_i) begin
            rb_shift_q <= {rb_shift_q[RB_W-2:0], 1'b0};
        end
    end

    always_comb begin
        so_d = 1'b0;
        if (diag_en_i) begin
            unique case (src)
                SO_SRC_REG:  so_d = rb_shift_q[RB_W-1];
                SO_SRC_SI:   so_d = si_lvl_i;
                SO_SRC_COMP: so_d = comp_lvl_i;
                SO_SRC_NONE: so_d = 1'b0;
                default:     so_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q <= 1'b0;
        end else begin
            so_q <= so_d;
        end
    end

    assign so_o = so_q;

    AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_en_i |=> !so_o); // R8

endmodule

// File: rtl/cfg_spi_bank.sv
module cfg_spi_bank
    import cfg_spi_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int WORD_W = WORD_W_DEF,
    localparam int DATA_W   = WORD_W - ADDR_W,
    localparam int NUM_REGS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    input  logic              comp_in,
    output logic              spi_so,
    output logic [DATA_W-1:0] freq_cfg,
    output logic [DATA_W-1:0] gain_cfg,
    output logic [DATA_W-1:0] integ_cfg,
    output logic [DATA_W-1:0] presc_cfg,
    output logic [DATA_W-1:0] test_cfg
);

    localparam int DIAG_BIT = DATA_W - 1;
    localparam int SRC_MSB  = DATA_W - 2;

    // lanes: 3 comp, 2 si, 1 sck, 0 cs
    logic [3:0] pin_lvl;
    logic [1:0] edge_rise, edge_fall;
    logic       commit;
    logic [WORD_W-1:0]          word;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic [ADDR_W-1:0]          last_addr;

    spi_pin_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_DEPTH),
        .RST_VAL (4'b0001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({comp_in, spi_si, spi_sck, spi_cs_n}),
        .lvl_o (pin_lvl)
    );

    spi_edge_det #(
        .WIDTH   (2),
        .RST_VAL (2'b01)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_lvl[1:0]),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    spi_frame_fsm #(
        .WORD_W (WORD_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_rise_i  (edge_rise[0]),
        .cs_fall_i  (edge_fall[0]),
        .sck_lvl_i  (pin_lvl[1]),
        .sck_rise_i (edge_rise[1]),
        .sck_fall_i (edge_fall[1]),
        .si_lvl_i   (pin_lvl[2]),
        .commit_o   (commit),
        .word_o     (word)
    );

    cfg_reg_file #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit),
        .word_i      (word),
        .regs_flat_o (regs_flat),
        .last_addr_o (last_addr)
    );

    assign freq_cfg  = regs_flat[0*DATA_W +: DATA_W];
    assign gain_cfg  = regs_flat[1*DATA_W +: DATA_W];
    assign integ_cfg = regs_flat[2*DATA_W +: DATA_W];
    assign presc_cfg = regs_flat[3*DATA_W +: DATA_W];
    assign test_cfg  = regs_flat[4*DATA_W +: DATA_W];

    diag_so_mux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_so (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_lvl_i    (pin_lvl[0]),
        .cs_fall_i   (edge_fall[0]),
        .sck_fall_i  (edge_fall[1]),
        .si_lvl_i    (pin_lvl[2]),
        .comp_lvl_i  (pin_lvl[3]),
        .regs_flat_i (regs_flat),
        .last_addr_i (last_addr),
        .diag_en_i   (test_cfg[DIAG_BIT]),
        .src_i       (test_cfg[SRC_MSB -: 2]),
        .so_o        (spi_so)
    );

    AST_SO_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!spi_so || !rst_n)); // R7

endmodule

// File: tb/cfg_spi_bank_bench.sv
module cfg_spi_bank_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, comp = 1'b0;
    logic so;
    logic [4:0] freq, gain, integ, presc, test;

    always #4 clk = ~clk;

    cfg_spi_bank u_cfg_spi_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_cs_n  (cs_n),
        .spi_sck   (sck),
        .spi_si    (si),
        .comp_in   (comp),
        .spi_so    (so),
        .freq_cfg  (freq),
        .gain_cfg  (gain),
        .integ_cfg (integ),
        .presc_cfg (presc),
        .test_cfg  (test)
    );

    int checks = 0;
    int errors = 0;
    logic [4:0] exp_r [5];
    logic [2:0] exp_last;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [4:0] port_of(input int r);
        case (r)
            0: return freq;
            1: return gain;
            2: return integ;
            3: return presc;
            default: return test;
        endcase
    endfunction

    function automatic bit frame_valid(input int nbits, input bit bad_start, input bit end_high);
        return (nbits == 8) && !bad_start && !end_high;
    endfunction

    task automatic check_regs(input string tag);
        for (int r = 0; r < 5; r++) begin
            chk(tag, $sformatf("reg%0d", r), {3'b0, port_of(r)}, {3'b0, exp_r[r]});
        end
    endtask

    task automatic send(input logic [7:0] w, input int nbits, input bit bad_start,
                        input bit end_high, input bit pre_chk, output logic [7:0] so_bits);
        so_bits = '0;
        if (bad_start) begin sck = 1'b1; cyc(8); end
        cs_n = 1'b0;
        cyc(8);
        if (bad_start) begin sck = 1'b0; cyc(8); end
        for (int i = 0; i < nbits; i++) begin
            si = (i < 8) ? w[7-i] : 1'b1;
            cyc(4);
            if (i < 8) so_bits[7-i] = so;
            sck = 1'b1;
            cyc(8);
            sck = 1'b0;
            cyc(4);
        end
        if (end_high) begin sck = 1'b1; cyc(8); end
        if (pre_chk) check_regs("R5");
        cs_n = 1'b1;
        cyc(8);
        if (end_high) begin sck = 1'b0; cyc(8); end
        cyc(4);
        if (frame_valid(nbits, bad_start, end_high) && w[7:5] < 3'd5) begin
            exp_r[w[7:5]] = w[4:0];
            exp_last      = w[7:5];
        end
    endtask

    task automatic write(input logic [2:0] a, input logic [4:0] d);
        logic [7:0] dummy;
        send({a, d}, 8, 1'b0, 1'b0, 1'b0, dummy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        int seed_dummy;
        seed_dummy = $urandom(32'd20517);
        for (int r = 0; r < 5; r++) exp_r[r] = '0;
        exp_last = '0;
        cyc(5);
        rst_n = 1'b1;
        cyc(4);
        // R7 reset state
        check_regs("R7");
        chk("R7", "so", {7'b0, so}, 8'h00);

        // R1 each register written
        write(3'd0, 5'h15); write(3'd1, 5'h0A); write(3'd2, 5'h13);
        write(3'd3, 5'h1F); write(3'd4, 5'h02);
        check_regs("R1");

        // R2 clock high at chip-select fall
        send({3'd1, 5'h11}, 8, 1'b1, 1'b0, 1'b0, rb);
        check_regs("R2");

        // R3 seven and nine pulses
        send({3'd0, 5'h04}, 7, 1'b0, 1'b0, 1'b0, rb);
        check_regs("R3");
        send({3'd0, 5'h08}, 9, 1'b0, 1'b0, 1'b0, rb);
        check_regs("R3");

        // R4 clock high at chip-select rise
        send({3'd3, 5'h01}, 8, 1'b0, 1'b1, 1'b0, rb);
        check_regs("R4");
        send({3'd3, 5'h02}, 7, 1'b0, 1'b1, 1'b0, rb);
        check_regs("R4");

        // R5 no change before chip-select rise
        send({3'd2, 5'h0C}, 8, 1'b0, 1'b0, 1'b1, rb);
        check_regs("R5");

        // R6 unused addresses
        send({3'd5, 5'h1F}, 8, 1'b0, 1'b0, 1'b0, rb);
        send({3'd6, 5'h1F}, 8, 1'b0, 1'b0, 1'b0, rb);
        send({3'd7, 5'h1F}, 8, 1'b0, 1'b0, 1'b0, rb);
        check_regs("R6");

        // R8 diag disabled, and source code 3
        write(3'd4, 5'b0_10_00);
        comp = 1'b1; si = 1'b1; cyc(6);
        chk("R8", "so off", {7'b0, so}, 8'h00);
        write(3'd4, 5'b1_11_00);
        si = 1'b1; comp = 1'b1; cyc(6);
        chk("R8", "so src3", {7'b0, so}, 8'h00);
        comp = 1'b0; si = 1'b0;

        // R9 readback of last written register
        write(3'd4, 5'b1_00_00);
        send(8'hE0, 8, 1'b0, 1'b0, 1'b0, rb);
        chk("R9", "readback test", rb, {3'd4, 5'b1_00_00});
        send(8'hA0, 8, 1'b0, 1'b0, 1'b0, rb);
        chk("R6", "readback addr kept", rb, {3'd4, 5'b1_00_00});
        write(3'd2, 5'h19);
        send(8'hE0, 8, 1'b0, 1'b0, 1'b0, rb);
        chk("R9", "readback integ", rb, {3'd2, 5'h19});

        // R10 follow serial input
        write(3'd4, 5'b1_01_00);
        si = 1'b1; cyc(6);
        chk("R10", "so=si 1", {7'b0, so}, 8'h01);
        si = 1'b0; cyc(6);
        chk("R10", "so=si 0", {7'b0, so}, 8'h00);

        // R11 follow comparator
        write(3'd4, 5'b1_10_00);
        comp = 1'b1; cyc(6);
        chk("R11", "so=comp 1", {7'b0, so}, 8'h01);
        comp = 1'b0; cyc(6);
        chk("R11", "so=comp 0", {7'b0, so}, 8'h00);

        // random frames
        for (int k = 0; k < 60; k++) begin
            logic [7:0] w;
            int nb;
            bit bs, eh;
            w  = 8'($urandom);
            case ($urandom % 6)
                0: nb = 7;
                1: nb = 9;
                default: nb = 8;
            endcase
            bs = (($urandom % 8) == 0);
            eh = (($urandom % 8) == 0);
            send(w, nb, bs, eh, 1'b0, rb);
            if (frame_valid(nb, bs, eh)) check_regs("R1");
            else check_regs("R3");
        end

        // R7 reset again mid-run
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        for (int r = 0; r < 5; r++) exp_r[r] = '0;
        check_regs("R7");
        chk("R7", "so after reset", {7'b0, so}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule